// File: doc/BRIEF.md
# Predicated Vector Long-Sum Reduction Unit

This unit reduces a 128-bit vector, viewed as four 32-bit lanes, into a single 64-bit sum. A 16-bit predicate, with one bit per byte of the vector, decides which lanes contribute. Each lane is widened to 64 bits before it is added. A control input chooses zero extension or sign extension. The 64-bit result is returned as a low word and a high word, the way a pair of 32-bit general registers would hold it.

The sum can start from zero or from an incoming high:low register pair. The unit handles one lane per clock, and each lane is called a beat. A start-beat input lets an operation resume partway through, after earlier beats were already done. In that case the incoming register pair always seeds the sum, even when accumulation is not requested. The caller also passes the register indices it would write. The unit rejects an illegal pair with an error pulse and leaves its result words untouched.

Top module: `vlong_sum_unit`

## Requirements
- R1: Lane e is vector bits [32e+31:32e], for e = 0 to 3. The enabled lanes are added into a 64-bit sum. The result is presented as `lo_word_o` = sum[31:0] and `hi_word_o` = sum[63:32].
- R2: Lane e takes part only when predicate bit 4e is 1. Predicate bits 4e+1 to 4e+3 have no effect on the result.
- R3: When `signed_i` is 0, each lane is zero-extended to 64 bits. When `signed_i` is 1, each lane is sign-extended to 64 bits.
- R4: When `accum_i` is 0 and `first_beat_i` is 0, the sum starts from zero.
- R5: When `accum_i` is 1, the sum starts from the 64-bit value {`hi_word_i`, `lo_word_i`}.
- R6: When `first_beat_i` is not zero, the sum starts from {`hi_word_i`, `lo_word_i`} whatever `accum_i` is. Only lanes `first_beat_i` to 3 are added.
- R7: A start is accepted only while `busy_o` is 0, and operands are sampled at that edge. `busy_o` is then 1 for 4 - `first_beat_i` cycles, one cycle per beat, including masked beats. In the cycle after the last beat, `done_o` is 1 for exactly one cycle and the new result is on the output words. A start while busy is ignored.
- R8: A request is invalid when `hi_idx_i` is 13 or 15, or when bit 0 of `lo_idx_i` is 1. An invalid request pulses `err_o` for one cycle on the next cycle, starts no run and leaves the result words unchanged.
- R9: Addition wraps modulo 2^64. No overflow or saturation indication exists.
- R10: After a clock edge with `rst_n` low, `busy_o`, `done_o` and `err_o` are 0 and both result words are 0.
- R11: The result words change only in a cycle where `done_o` is 1, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a reduction (taken while idle) |
| lanes_i | input | 128 | Source vector, four 32-bit lanes |
| pred_i | input | 16 | Per-byte predicate; bit 4e enables lane e |
| signed_i | input | 1 | 1: sign-extend lanes, 0: zero-extend |
| accum_i | input | 1 | 1: start from incoming register pair |
| first_beat_i | input | 2 | First lane to process (0 to 3) |
| lo_word_i | input | 32 | Incoming low register word |
| hi_word_i | input | 32 | Incoming high register word |
| lo_idx_i | input | 4 | Destination low register index |
| hi_idx_i | input | 4 | Destination high register index |
| busy_o | output | 1 | Reduction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid-request pulse |
| lo_word_o | output | 32 | Result bits 31:0 |
| hi_word_o | output | 32 | Result bits 63:32 |

## Verification
Several behaviours are checked by assertions on every cycle:
- the completion and error pulses last a single cycle;
- an error never coincides with a run or a completion;
- a bad high index always yields an error;
- the result words hold between completions;
- reset leaves the unit idle.

The arithmetic itself can only be shown by the bench's scenarios, which compare against a behavioural model every clock. These cover lane selection by predicate bit 4e, signed against unsigned widening, the seeding choice between zero and the register pair (including a mid-operation restart), wrap-around at 2^64, and a start ignored while busy.

// File: rtl/vls_pkg.sv
// Package vls_pkg: shared types and helpers for the long-sum reduction unit.
// Assumes register indices are 4 bits wide.
package vls_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} vls_state_e;

    // Reject a destination pair that cannot be written.
    function automatic logic idx_bad(input logic [3:0] hi_idx, input logic [3:0] lo_idx);
        return (hi_idx == 4'd13) || (hi_idx == 4'd15) || lo_idx[0];
    endfunction
endpackage

// File: rtl/vls_lane_pick.sv
// Module vls_lane_pick: selects the lane addressed by the current beat.
// Widens it to the accumulator width and reports whether its predicate
// bit enables it. Purely combinational. Assumes LANES is a power of two.
module vls_lane_pick #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int ACC_W  = 2 * LANE_W,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int GRP    = LANE_W / 8,
    localparam int PRED_W = LANES * GRP,
    localparam int BEAT_W = $clog2(LANES)
) (
    input  logic [VEC_W-1:0]  lanes_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              signed_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [ACC_W-1:0]  ext_o,
    output logic              en_o
);
    logic [ACC_W-1:0] ext_arr [LANES];
    logic [LANES-1:0] en_vec;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane;
        logic              fill;
        // Slice the lane and widen it per the extension mode.
        always_comb begin
            lane       = lanes_i[g*LANE_W +: LANE_W];
            fill       = signed_i & lane[LANE_W-1];
            ext_arr[g] = {{LANE_W{fill}}, lane};
            en_vec[g]  = pred_i[g*GRP];
        end
    end

    // Route the addressed lane to the adder.
    always_comb begin
        ext_o = ext_arr[beat_i];
        en_o  = en_vec[beat_i];
    end
endmodule

// File: rtl/vls_ctrl.sv
// Module vls_ctrl: sequencer for the reduction.
// Accepts a start while idle, validates the destination indices and steps
// one beat per clock from the start beat to the last lane. Produces the
// one-cycle done and error pulses.
module vls_ctrl
    import vls_pkg::*;
#(
    parameter int LANES = 4,
    localparam int BEAT_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BEAT_W-1:0] first_beat_i,
    input  logic [3:0]        lo_idx_i,
    input  logic [3:0]        hi_idx_i,
    output logic              load_o,
    output logic              step_o,
    output logic              last_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LANES - 1);

    vls_state_e  state_q;
    logic [BEAT_W-1:0] beat_q;
    logic        accept;
    logic        bad;

    // Decode acceptance and the per-cycle controls.
    always_comb begin
        accept = start_i && (state_q == ST_IDLE);
        bad    = idx_bad(hi_idx_i, lo_idx_i);
        load_o = accept && !bad;
        step_o = (state_q == ST_RUN);
        last_o = step_o && (beat_q == LAST_BEAT);
        beat_o = beat_q;
        busy_o = (state_q == ST_RUN);
    end

    // State, beat counter and completion/error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && bad) begin
                        err_o <= 1'b1;
                    end else if (accept) begin
                        state_q <= ST_RUN;
                        beat_q  <= first_beat_i;
                    end
                end
                default: begin
                    if (beat_q == LAST_BEAT) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vls_accum.sv
// Module vls_accum: running 64-bit sum and the result register.
// Seeds on load, adds one enabled lane per step modulo 2^ACC_W, and
// copies the final sum to the result on the last step.
module vls_accum #(
    parameter int LANE_W = 32,
    localparam int ACC_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W-1:0]  seed_i,
    input  logic              step_i,
    input  logic              last_i,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  ext_i,
    output logic [ACC_W-1:0]  res_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;

    // Add the current lane when enabled (wraps naturally).
    always_comb begin
        acc_next = acc_q + (en_i ? ext_i : '0);
    end

    // Accumulator and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            res_o <= '0;
        end else begin
            if (load_i) begin
                acc_q <= seed_i;
            end else if (step_i) begin
                acc_q <= acc_next;
            end
            if (last_i) begin
                res_o <= acc_next;
            end
        end
    end
endmodule

// File: rtl/vlong_sum_unit.sv
// Module vlong_sum_unit: predicated long-sum reduction of a vector into a
// high/low register pair. Captures operands on an accepted start and then
// processes one lane per clock. Register access and predicate updates
// belong to the caller.
module vlong_sum_unit #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int ACC_W  = 2 * LANE_W,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int PRED_W = LANES * (LANE_W / 8),
    localparam int BEAT_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  lanes_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              signed_i,
    input  logic              accum_i,
    input  logic [BEAT_W-1:0] first_beat_i,
    input  logic [LANE_W-1:0] lo_word_i,
    input  logic [LANE_W-1:0] hi_word_i,
    input  logic [3:0]        lo_idx_i,
    input  logic [3:0]        hi_idx_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [LANE_W-1:0] lo_word_o,
    output logic [LANE_W-1:0] hi_word_o
);
    logic              load, step, last, lane_en;
    logic [BEAT_W-1:0] beat;
    logic [VEC_W-1:0]  lanes_q;
    logic [PRED_W-1:0] pred_q;
    logic              sign_q;
    logic [ACC_W-1:0]  seed, ext, res;

    vls_ctrl #(.LANES(LANES)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .first_beat_i(first_beat_i), .lo_idx_i(lo_idx_i), .hi_idx_i(hi_idx_i),
        .load_o(load), .step_o(step), .last_o(last), .beat_o(beat),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    // Seed: register pair when accumulating or resuming, else zero.
    always_comb begin
        seed = (accum_i || (first_beat_i != '0)) ? {hi_word_i, lo_word_i} : '0;
    end

    // Hold the vector operands for the duration of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= '0;
            pred_q  <= '0;
            sign_q  <= 1'b0;
        end else if (load) begin
            lanes_q <= lanes_i;
            pred_q  <= pred_i;
            sign_q  <= signed_i;
        end
    end

    vls_lane_pick #(.LANE_W(LANE_W), .LANES(LANES)) i_pick (
        .lanes_i(lanes_q), .pred_i(pred_q), .signed_i(sign_q),
        .beat_i(beat), .ext_o(ext), .en_o(lane_en)
    );

    vls_accum #(.LANE_W(LANE_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed),
        .step_i(step), .last_i(last), .en_i(lane_en), .ext_i(ext),
        .res_o(res)
    );

    // Split the result into the two register words.
    always_comb begin
        lo_word_o = res[LANE_W-1:0];
        hi_word_o = res[ACC_W-1:LANE_W];
    end
endmodule

// File: rtl/vls_chk.sv
// Module vls_chk: protocol and hold properties of vlong_sum_unit, observed
// at its ports only. Bound to every instance of the top module.
module vls_chk #(
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int PRED_W = LANES * (LANE_W / 8),
    localparam int BEAT_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [VEC_W-1:0]  lanes_i,
    input logic [PRED_W-1:0] pred_i,
    input logic              signed_i,
    input logic              accum_i,
    input logic [BEAT_W-1:0] first_beat_i,
    input logic [LANE_W-1:0] lo_word_i,
    input logic [LANE_W-1:0] hi_word_i,
    input logic [3:0]        lo_idx_i,
    input logic [3:0]        hi_idx_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [LANE_W-1:0] lo_word_o,
    input logic [LANE_W-1:0] hi_word_o
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !done_o));

    // R8
    bad_hi_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((hi_idx_i == 4'd13) || (hi_idx_i == 4'd15))) |=> err_o);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({hi_word_o, lo_word_o}));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !err_o && lo_word_o == '0 && hi_word_o == '0));
endmodule

bind vlong_sum_unit vls_chk #(.LANE_W(LANE_W), .LANES(LANES)) i_chk (.*);

// File: tb/test_vlong_sum_unit.sv
// Bench: behavioural reference model compared at every falling edge.
module test_vlong_sum_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] lanes_i = '0;
    logic [15:0]  pred_i = '0;
    logic         signed_i = 1'b0, accum_i = 1'b0;
    logic [1:0]   first_beat_i = '0;
    logic [31:0]  lo_word_i = '0, hi_word_i = '0;
    logic [3:0]   lo_idx_i = 4'd0, hi_idx_i = 4'd1;
    logic         busy_o, done_o, err_o;
    logic [31:0]  lo_word_o, hi_word_o;

    int    checks = 0, fails = 0;
    string cur_req = "R10";
    bit    chk_on = 1'b0;

    // reference model state
    bit          m_busy, m_done, m_err;
    int          m_cnt;
    logic [63:0] m_res, m_out;

    always #2 clk = ~clk;

    vlong_sum_unit i_vlong_sum_unit (.*);

    function automatic logic [63:0] ref_sum();
        logic [63:0] s;
        s = (accum_i || first_beat_i != 0) ? {hi_word_i, lo_word_i} : 64'd0;
        for (int e = int'(first_beat_i); e < 4; e++) begin
            logic [31:0] w;
            w = lanes_i[32*e +: 32];
            if (pred_i[4*e]) begin
                if (signed_i) s = s + 64'($signed(w));
                else          s = s + {32'd0, w};
            end
        end
        return s;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_out = '0; m_res = '0;
        end else begin
            m_done = 0; m_err = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_out = m_res; end
            end else if (start_i) begin
                if (hi_idx_i == 13 || hi_idx_i == 15 || lo_idx_i[0]) m_err = 1;
                else begin m_busy = 1; m_cnt = 4 - int'(first_beat_i); m_res = ref_sum(); end
            end
        end
    end

    task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) if (chk_on) begin
        cmp("busy", 64'(busy_o), 64'(m_busy));
        cmp("done", 64'(done_o), 64'(m_done));
        cmp("err",  64'(err_o),  64'(m_err));
        cmp("result", {hi_word_o, lo_word_o}, m_out);
    end

    task automatic go(logic [127:0] v, logic [15:0] p, bit s, bit a, logic [1:0] fb,
                      logic [63:0] seed, logic [3:0] hix, logic [3:0] lix, int wait_cyc);
        @(negedge clk);
        lanes_i = v; pred_i = p; signed_i = s; accum_i = a; first_beat_i = fb;
        {hi_word_i, lo_word_i} = seed; hi_idx_i = hix; lo_idx_i = lix; start_i = 1;
        @(negedge clk);
        start_i = 0;
        // scramble operands: the run must use the sampled values (R7)
        lanes_i = ~v; pred_i = ~p; {hi_word_i, lo_word_i} = ~seed;
        repeat (wait_cyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        chk_on = 1;
        @(negedge clk);
        rst_n = 1;
        // R1: all lanes, unsigned, from zero
        cur_req = "R1";
        go({32'd4, 32'd3, 32'd2, 32'd1}, 16'hFFFF, 0, 0, 0, 64'h55, 1, 0, 6);
        // R2: only bit 4e counts; 0xEEEE adds nothing
        cur_req = "R2";
        go({32'd40, 32'd30, 32'd20, 32'd10}, 16'h0101, 0, 0, 0, 0, 3, 2, 6);
        go({32'd40, 32'd30, 32'd20, 32'd10}, 16'hEEEE, 0, 1, 0, 64'h1234, 3, 2, 6);
        // R3: signed vs unsigned of the same negative lanes
        cur_req = "R3";
        go({4{32'hFFFF_FFFE}}, 16'h1111, 1, 0, 0, 0, 5, 4, 6);
        go({4{32'hFFFF_FFFE}}, 16'h1111, 0, 0, 0, 0, 5, 4, 6);
        // R4 / R5: seed from zero vs register pair
        cur_req = "R4";
        go({32'd1, 32'd1, 32'd1, 32'd1}, 16'hFFFF, 0, 0, 0, 64'hDEAD_0000_BEEF, 7, 6, 6);
        cur_req = "R5";
        go({32'd1, 32'd1, 32'd1, 32'd1}, 16'hFFFF, 1, 1, 0, 64'h1_0000_0000, 7, 6, 6);
        // R6: resume at beats 2 and 3 with accumulate off
        cur_req = "R6";
        go({32'd8, 32'd4, 32'd2, 32'd1}, 16'hFFFF, 0, 0, 2, 64'd100, 9, 8, 4);
        go({32'd8, 32'd4, 32'd2, 32'd1}, 16'hFFFF, 0, 0, 3, 64'd100, 9, 8, 3);
        // R7: a start during the run is ignored
        cur_req = "R7";
        go({32'd5, 32'd6, 32'd7, 32'd8}, 16'hFFFF, 0, 0, 0, 0, 1, 0, 1);
        start_i = 1; lanes_i = '1;
        @(negedge clk); start_i = 0;
        repeat (5) @(negedge clk);
        // R8: bad indices (hi 13, hi 15, odd lo) raise error, keep result
        cur_req = "R8";
        go('1, 16'hFFFF, 0, 1, 0, 64'h77, 13, 0, 3);
        go('1, 16'hFFFF, 0, 1, 0, 64'h77, 15, 0, 3);
        go('1, 16'hFFFF, 0, 1, 0, 64'h77, 1, 3, 3);
        // R9: wrap past 2^64
        cur_req = "R9";
        go({4{32'hFFFF_FFFF}}, 16'hFFFF, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 6);
        // R11: outputs hold after idle cycles
        cur_req = "R11";
        repeat (4) @(negedge clk);
        // R10: reset clears everything
        cur_req = "R10";
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        fails++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule